// File: doc/BRIEF.md
# Microcontroller Low-Power Mode Controller

This block sits in the always-on part of a small 8-bit microcontroller and decides when the CPU clock and the oscillator run. Software writes a 4-bit power-control register. Bit 0 asks for idle mode and bit 1 asks for power-down mode. Bits 2 and 3 are two general-purpose flags that software can use to tell, after wake-up, whether an interrupt arrived while the core was asleep.

In idle mode the oscillator keeps running and only the CPU clock stops. Any enabled interrupt, or a hardware reset held long enough, returns the core to normal running. In power-down mode the oscillator also stops. Interrupts are ignored, and only the hardware reset pin ends the mode. After that reset is released, the CPU clock stays stopped until a stabilisation count has expired.

While the core sleeps, the block drives the address-latch and program-store strobes and the four 8-bit ports. Their levels depend on the mode and on whether code runs from internal or external program memory. While the core runs, the core's own strobe and port values pass straight through.

Top module: `lowpower_ctrl`

## Requirements
- R1: In running mode, a register write goes to power-down on the next clock edge when data bit 1 is set, even if bit 0 is also set. It goes to idle when only bit 0 is set. With neither bit set it stays running. Bits 3:2 are stored as flags. pconRead shows {flag1, flag0, power-down bit, idle bit}, and only one mode bit is ever set.
- R2: The flags keep their value through idle entry and interrupt wake-up. The idle bit reads 0 after the wake-up.
- R3: In idle mode, any interrupt request whose enable bit is also set returns the block to running on the next edge. Requests whose enable is clear do not wake it.
- R4: cpuClkEn and oscEn are both 1 while running. In idle, cpuClkEn is 0 and oscEn is 1. In power-down both are 0. During oscillator restart, cpuClkEn is 0 and oscEn is 1.
- R5: In power-down, interrupts have no effect. One sampled cycle of hwRst moves the block to oscillator restart, sets oscEn to 1 and clears the whole register.
- R6: During restart, cpuClkEn becomes 1 at the STABLE_CYCLES-th consecutive clock edge that samples hwRst low. A new hwRst high during restart restarts the count.
- R7: While running or idle, hwRst takes effect at the RST_CYCLES-th consecutive edge that samples it high. At that edge the register clears, idle ends, and coreRstOut goes to 1 until hwRst is sampled low. A shorter pulse changes nothing.
- R8: In idle mode, ale and psen are both 1. In power-down and restart, both are 0.
- R9: With extCode at 0, all four ports drive their latch values in idle, power-down and restart, and p0Float is 0.
- R10: With extCode at 1 in idle mode, p0Float is 1, p2 drives addrHi, and p1 and p3 drive their latches.
- R11: With extCode at 1 in power-down or restart, p0Float is 1, p2 drives latch2, and p1 and p3 drive their latches.
- R12: While running, ale, psen, p0, p0Float and p2 follow runAle, runPsen, runP0, runP0Float and runP2. p1 and p3 follow their latches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-domain clock |
| rstN | input | 1 | Always-on power-on reset, active low, asynchronous |
| hwRst | input | 1 | Hardware reset pin, active high |
| regWrEn | input | 1 | Power-control register write strobe |
| regWrData | input | 4 | Write data {flag1, flag0, power-down, idle} |
| irqReq | input | NUM_IRQ | Interrupt requests |
| irqEn | input | NUM_IRQ | Interrupt enables |
| extCode | input | 1 | 1 when code runs from external program memory |
| latch0 | input | PORT_W | Port 0 latch value |
| latch1 | input | PORT_W | Port 1 latch value |
| latch2 | input | PORT_W | Port 2 latch value |
| latch3 | input | PORT_W | Port 3 latch value |
| addrHi | input | PORT_W | Upper address byte held by the core |
| runAle | input | 1 | Core address-latch strobe while running |
| runPsen | input | 1 | Core program-store strobe while running |
| runP0 | input | PORT_W | Core port 0 value while running |
| runP0Float | input | 1 | Core port 0 float control while running |
| runP2 | input | PORT_W | Core port 2 value while running |
| cpuClkEn | output | 1 | CPU clock enable |
| oscEn | output | 1 | Oscillator enable |
| coreRstOut | output | 1 | Accepted reset to the core |
| pconRead | output | 4 | Register read value |
| ale | output | 1 | Address-latch strobe pin level |
| psen | output | 1 | Program-store strobe pin level |
| p0 | output | PORT_W | Port 0 drive value |
| p0Float | output | 1 | Port 0 float control |
| p1 | output | PORT_W | Port 1 drive value |
| p2 | output | PORT_W | Port 2 drive value |
| p3 | output | PORT_W | Port 3 drive value |

## Verification
The assertions check several rules on every clock cycle:
- the strobe levels and the port 0 float control for each sleep mode;
- that power-down holds while hwRst is low, whatever the interrupts do;
- that an enabled interrupt in idle restores the CPU clock on the next edge;
- the priority of power-down over idle in a single write;
- that a reset in power-down clears the register and restarts the oscillator.

Other behaviour depends on long counts and on sequences, so only the bench scenarios can show it. These are the exact edge at which the stabilisation count and the reset-length count complete, the rejection of a short reset pulse, and the flags surviving an idle round trip. The bench's reference model compares every output on every cycle throughout those scenarios.

// File: rtl/lowpower_pkg.sv
package lowpower_pkg;
  localparam int PCON_W    = 4;
  localparam int IDLE_BIT  = 0;
  localparam int PDOWN_BIT = 1;

  typedef enum logic [1:0] {
    MODE_RUN     = 2'd0,
    MODE_IDLE    = 2'd1,
    MODE_PDOWN   = 2'd2,
    MODE_RESTART = 2'd3
  } lpMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic wrAllow;
    logic clearReg;
    logic clearIdle;
    logic pinIdle;
    logic pinSleep;
  } lpStrobe_t;
endpackage

// File: rtl/lowpower_ctrl_fsm.sv
module lowpower_ctrl_fsm
  import lowpower_pkg::*;
#(
  parameter int NUM_IRQ       = 5,
  parameter int RST_CYCLES    = 24,
  parameter int STABLE_CYCLES = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hwRst,
  input  logic [NUM_IRQ-1:0] irqReq,
  input  logic [NUM_IRQ-1:0] irqEn,
  input  logic               reqIdle,
  input  logic               reqPdown,
  output lpStrobe_t          strobe,
  output lpMode_e            mode,
  output logic               cpuClkEn,
  output logic               oscEn,
  output logic               coreRstOut
);
  localparam int RW = $clog2(RST_CYCLES + 1);
  localparam int SW = $clog2(STABLE_CYCLES + 1);
  localparam logic [RW-1:0] RST_MAX  = RW'(RST_CYCLES);
  localparam logic [RW-1:0] RST_LAST = RW'(RST_CYCLES - 1);
  localparam logic [SW-1:0] STB_LAST = SW'(STABLE_CYCLES - 1);

  lpMode_e       modeNext;
  logic [RW-1:0] rstCnt;
  logic [SW-1:0] stabCnt;
  logic          rstFull;
  logic          wake;

  assign rstFull = hwRst && (rstCnt >= RST_LAST);
  assign wake    = |(irqReq & irqEn);

  always_comb begin
    modeNext = mode;
    unique case (mode)
      MODE_RUN: begin
        if (!rstFull) begin
          if (reqPdown)     modeNext = MODE_PDOWN;
          else if (reqIdle) modeNext = MODE_IDLE;
        end
      end
      MODE_IDLE:  if (rstFull || wake) modeNext = MODE_RUN;
      MODE_PDOWN: if (hwRst) modeNext = MODE_RESTART;
      MODE_RESTART: if (!hwRst && stabCnt == STB_LAST) modeNext = MODE_RUN;
      default: modeNext = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode    <= MODE_RUN;
      rstCnt  <= '0;
      stabCnt <= '0;
    end else begin
      mode <= modeNext;
      if (!hwRst)              rstCnt <= '0;
      else if (rstCnt != RST_MAX) rstCnt <= rstCnt + 1'b1;
      if (mode == MODE_RESTART && !hwRst) stabCnt <= stabCnt + 1'b1;
      else                                stabCnt <= '0;
    end
  end

  always_comb begin
    strobe.wrAllow   = (mode == MODE_RUN) && !rstFull;
    strobe.clearReg  = rstFull || (mode == MODE_PDOWN && hwRst);
    strobe.clearIdle = (mode == MODE_IDLE) && wake;
    strobe.pinIdle   = (mode == MODE_IDLE);
    strobe.pinSleep  = (mode == MODE_PDOWN) || (mode == MODE_RESTART);
  end

  assign cpuClkEn   = (mode == MODE_RUN);
  assign oscEn      = (mode != MODE_PDOWN);
  assign coreRstOut = (rstCnt == RST_MAX);
endmodule

// File: rtl/lowpower_pin_path.sv
module lowpower_pin_path
  import lowpower_pkg::*;
#(
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  lpStrobe_t         strobe,
  input  logic              regWrEn,
  input  logic [PCON_W-1:0] regWrData,
  input  logic              extCode,
  input  logic [PORT_W-1:0] latch0,
  input  logic [PORT_W-1:0] latch1,
  input  logic [PORT_W-1:0] latch2,
  input  logic [PORT_W-1:0] latch3,
  input  logic [PORT_W-1:0] addrHi,
  input  logic              runAle,
  input  logic              runPsen,
  input  logic [PORT_W-1:0] runP0,
  input  logic              runP0Float,
  input  logic [PORT_W-1:0] runP2,
  output logic              reqIdle,
  output logic              reqPdown,
  output logic [PCON_W-1:0] pconRead,
  output logic              ale,
  output logic              psen,
  output logic [PORT_W-1:0] p0,
  output logic              p0Float,
  output logic [PORT_W-1:0] p1,
  output logic [PORT_W-1:0] p2,
  output logic [PORT_W-1:0] p3
);
  logic [PCON_W-1:0] pcon;
  logic              wrTake;
  logic              asleep;

  assign wrTake   = regWrEn && strobe.wrAllow;
  assign reqPdown = wrTake && regWrData[PDOWN_BIT];
  assign reqIdle  = wrTake && regWrData[IDLE_BIT] && !regWrData[PDOWN_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcon <= '0;
    end else if (strobe.clearReg) begin
      pcon <= '0;
    end else if (wrTake) begin
      pcon            <= regWrData;
      pcon[IDLE_BIT]  <= regWrData[IDLE_BIT] && !regWrData[PDOWN_BIT];
    end else if (strobe.clearIdle) begin
      pcon[IDLE_BIT]  <= 1'b0;
    end
  end
  assign pconRead = pcon;

  assign asleep = strobe.pinIdle || strobe.pinSleep;

  // ports 1 and 3 always carry their latch
  assign p1 = latch1;
  assign p3 = latch3;

  always_comb begin
    if (!asleep) begin
      ale     = runAle;
      psen    = runPsen;
      p0      = runP0;
      p0Float = runP0Float;
      p2      = runP2;
    end else begin
      ale     = strobe.pinIdle;
      psen    = strobe.pinIdle;
      p0      = latch0;
      p0Float = extCode;
      p2      = (extCode && strobe.pinIdle) ? addrHi : latch2;
    end
  end
endmodule

// File: rtl/lowpower_ctrl.sv
module lowpower_ctrl
  import lowpower_pkg::*;
#(
  parameter int NUM_IRQ       = 5,
  parameter int PORT_W        = 8,
  parameter int RST_CYCLES    = 24,
  parameter int STABLE_CYCLES = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hwRst,
  input  logic               regWrEn,
  input  logic [3:0]         regWrData,
  input  logic [NUM_IRQ-1:0] irqReq,
  input  logic [NUM_IRQ-1:0] irqEn,
  input  logic               extCode,
  input  logic [PORT_W-1:0]  latch0,
  input  logic [PORT_W-1:0]  latch1,
  input  logic [PORT_W-1:0]  latch2,
  input  logic [PORT_W-1:0]  latch3,
  input  logic [PORT_W-1:0]  addrHi,
  input  logic               runAle,
  input  logic               runPsen,
  input  logic [PORT_W-1:0]  runP0,
  input  logic               runP0Float,
  input  logic [PORT_W-1:0]  runP2,
  output logic               cpuClkEn,
  output logic               oscEn,
  output logic               coreRstOut,
  output logic [3:0]         pconRead,
  output logic               ale,
  output logic               psen,
  output logic [PORT_W-1:0]  p0,
  output logic               p0Float,
  output logic [PORT_W-1:0]  p1,
  output logic [PORT_W-1:0]  p2,
  output logic [PORT_W-1:0]  p3
);
  lpStrobe_t strobe;
  lpMode_e   curMode;
  logic      reqIdle;
  logic      reqPdown;

  lowpower_ctrl_fsm #(
    .NUM_IRQ(NUM_IRQ), .RST_CYCLES(RST_CYCLES), .STABLE_CYCLES(STABLE_CYCLES)
  ) u_fsm (
    .clk(clk), .rstN(rstN), .hwRst(hwRst), .irqReq(irqReq), .irqEn(irqEn),
    .reqIdle(reqIdle), .reqPdown(reqPdown), .strobe(strobe), .mode(curMode),
    .cpuClkEn(cpuClkEn), .oscEn(oscEn), .coreRstOut(coreRstOut)
  );

  lowpower_pin_path #(.PORT_W(PORT_W)) u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regWrEn(regWrEn),
    .regWrData(regWrData), .extCode(extCode), .latch0(latch0), .latch1(latch1),
    .latch2(latch2), .latch3(latch3), .addrHi(addrHi), .runAle(runAle),
    .runPsen(runPsen), .runP0(runP0), .runP0Float(runP0Float), .runP2(runP2),
    .reqIdle(reqIdle), .reqPdown(reqPdown), .pconRead(pconRead), .ale(ale),
    .psen(psen), .p0(p0), .p0Float(p0Float), .p1(p1), .p2(p2), .p3(p3)
  );
endmodule

// File: rtl/lowpower_ctrl_checker.sv
module lowpower_ctrl_checker
  import lowpower_pkg::*;
#(
  parameter int NUM_IRQ = 5
) (
  input logic               clk,
  input logic               rstN,
  input logic               hwRst,
  input logic               regWrEn,
  input logic [3:0]         regWrData,
  input logic [NUM_IRQ-1:0] irqReq,
  input logic [NUM_IRQ-1:0] irqEn,
  input logic               extCode,
  input lpMode_e            curMode,
  input logic               cpuClkEn,
  input logic               oscEn,
  input logic [3:0]         pconRead,
  input logic               ale,
  input logic               psen,
  input logic               p0Float
);
  assert_pdown_priority_R1: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == MODE_RUN && regWrEn && regWrData[1] && !hwRst) |=> (curMode == MODE_PDOWN && pconRead[1:0] == 2'b10));

  assert_irq_wake_R3: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == MODE_IDLE && |(irqReq & irqEn)) |=> cpuClkEn);

  assert_idle_osc_R4: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == MODE_IDLE) |-> (oscEn && !cpuClkEn));

  assert_pdown_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == MODE_PDOWN && !hwRst) |=> (curMode == MODE_PDOWN && !oscEn));

  assert_pdown_exit_R5: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == MODE_PDOWN && hwRst) |=> (oscEn && !cpuClkEn && pconRead == 4'b0000));

  assert_restart_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == MODE_RESTART && hwRst) |=> !cpuClkEn);

  assert_idle_strobes_R8: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == MODE_IDLE) |-> (ale && psen));

  assert_sleep_strobes_R8: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == MODE_PDOWN || curMode == MODE_RESTART) |-> (!ale && !psen));

  assert_ext_float_R10: assert property (@(posedge clk) disable iff (!rstN)
    (curMode != MODE_RUN && extCode) |-> p0Float);

  assert_int_nofloat_R9: assert property (@(posedge clk) disable iff (!rstN)
    (curMode != MODE_RUN && !extCode) |-> !p0Float);
endmodule

bind lowpower_ctrl lowpower_ctrl_checker #(.NUM_IRQ(NUM_IRQ)) u_checker (
  .clk(clk), .rstN(rstN), .hwRst(hwRst), .regWrEn(regWrEn), .regWrData(regWrData),
  .irqReq(irqReq), .irqEn(irqEn), .extCode(extCode), .curMode(curMode),
  .cpuClkEn(cpuClkEn), .oscEn(oscEn), .pconRead(pconRead), .ale(ale),
  .psen(psen), .p0Float(p0Float)
);

// File: tb/test_lowpower_ctrl.sv
`timescale 1ns/1ps
module test_lowpower_ctrl;
  localparam int NUM_IRQ       = 5;
  localparam int PORT_W        = 8;
  localparam int RST_CYCLES    = 24;
  localparam int STABLE_CYCLES = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic               rstN = 1'b0;
  logic               hwRst = 1'b0;
  logic               regWrEn = 1'b0;
  logic [3:0]         regWrData = '0;
  logic [NUM_IRQ-1:0] irqReq = '0;
  logic [NUM_IRQ-1:0] irqEn = '0;
  logic               extCode = 1'b0;
  logic [PORT_W-1:0]  latch0 = 8'hA0, latch1 = 8'hB1, latch2 = 8'hC2, latch3 = 8'hD3;
  logic [PORT_W-1:0]  addrHi = 8'h7E;
  logic               runAle = 1'b0, runPsen = 1'b1, runP0Float = 1'b0;
  logic [PORT_W-1:0]  runP0 = 8'h5C, runP2 = 8'h3F;
  logic               cpuClkEn, oscEn, coreRstOut, ale, psen, p0Float;
  logic [3:0]         pconRead;
  logic [PORT_W-1:0]  p0, p1, p2, p3;

  lowpower_ctrl #(.NUM_IRQ(NUM_IRQ), .PORT_W(PORT_W), .RST_CYCLES(RST_CYCLES),
                  .STABLE_CYCLES(STABLE_CYCLES)) i_lowpower_ctrl (
    .clk(clk), .rstN(rstN), .hwRst(hwRst), .regWrEn(regWrEn), .regWrData(regWrData),
    .irqReq(irqReq), .irqEn(irqEn), .extCode(extCode), .latch0(latch0), .latch1(latch1),
    .latch2(latch2), .latch3(latch3), .addrHi(addrHi), .runAle(runAle), .runPsen(runPsen),
    .runP0(runP0), .runP0Float(runP0Float), .runP2(runP2), .cpuClkEn(cpuClkEn),
    .oscEn(oscEn), .coreRstOut(coreRstOut), .pconRead(pconRead), .ale(ale), .psen(psen),
    .p0(p0), .p0Float(p0Float), .p1(p1), .p2(p2), .p3(p3)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model: 0 run, 1 idle, 2 power-down, 3 restart
  int         mMode = 0;
  int         mRstRun = 0;
  int         mStab = 0;
  logic [3:0] mReg = '0;

  always @(posedge clk) begin
    if (!rstN) begin
      mMode = 0; mRstRun = 0; mStab = 0; mReg = '0;
    end else begin
      bit full;
      bit wake;
      int nMode;
      logic [3:0] nReg;
      full  = hwRst && (mRstRun >= RST_CYCLES - 1);
      wake  = (irqReq & irqEn) != 0;
      nMode = mMode;
      nReg  = mReg;
      case (mMode)
        0: begin
          if (full) nReg = '0;
          else if (regWrEn) begin
            nReg = {regWrData[3:2], regWrData[1], regWrData[0] & ~regWrData[1]};
            if (regWrData[1]) nMode = 2;
            else if (regWrData[0]) nMode = 1;
          end
        end
        1: begin
          if (full) begin nReg = '0; nMode = 0; end
          else if (wake) begin nReg[0] = 1'b0; nMode = 0; end
        end
        2: if (hwRst) begin nReg = '0; nMode = 3; end
        default: begin
          if (full) nReg = '0;
          if (!hwRst && mStab == STABLE_CYCLES - 1) nMode = 0;
        end
      endcase
      mStab   = (mMode == 3 && !hwRst) ? mStab + 1 : 0;
      mRstRun = hwRst ? ((mRstRun < RST_CYCLES) ? mRstRun + 1 : mRstRun) : 0;
      mMode   = nMode;
      mReg    = nReg;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    logic eAle, ePsen, eFloat;
    logic [PORT_W-1:0] eP0, eP2;
    if (mMode == 0) begin
      eAle = runAle; ePsen = runPsen; eP0 = runP0; eFloat = runP0Float; eP2 = runP2;
    end else begin
      eAle = (mMode == 1); ePsen = (mMode == 1); eP0 = latch0; eFloat = extCode;
      eP2 = (mMode == 1 && extCode) ? addrHi : latch2;
    end
    check("R4 cpuClkEn", cpuClkEn, mMode == 0);
    check("R4 oscEn", oscEn, mMode != 2);
    check("R1 R2 pconRead", pconRead, mReg);
    check("R7 coreRstOut", coreRstOut, mRstRun == RST_CYCLES);
    check("R8 R12 ale", ale, eAle);
    check("R8 R12 psen", psen, ePsen);
    check("R9 R12 p0", p0, eP0);
    check("R10 R11 p0Float", p0Float, eFloat);
    check("R10 R11 p2", p2, eP2);
    check("R9 p1", p1, latch1);
    check("R9 p3", p3, latch3);
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compareAll();
    end
  endtask

  task automatic writeReg(logic [3:0] d);
    regWrEn = 1'b1; regWrData = d;
    step();
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    step(3);
    rstN = 1'b1;
    step();
    check("R4 reset state clock", cpuClkEn, 1);
    check("R1 reset state register", pconRead, 4'h0);

    // R12 pass-through while running
    runAle = 1'b1; runPsen = 1'b0; runP0 = 8'h11; runP0Float = 1'b1; runP2 = 8'h22;
    step(2);
    check("R12 run p2", p2, 8'h22);

    // R1 flags only
    writeReg(4'b1100);
    check("R1 flags only stays running", cpuClkEn, 1);
    check("R1 flags stored", pconRead, 4'b1100);

    // R1 idle entry, R3 masked irq, R2 flags kept
    writeReg(4'b0101);
    check("R1 idle entered", cpuClkEn, 0);
    check("R8 idle ale", ale, 1);
    irqReq = 5'b00100; irqEn = 5'b01011;
    step(4);
    check("R3 masked irq ignored", cpuClkEn, 0);
    extCode = 1'b1;
    step();
    check("R10 idle ext p2 address", p2, 8'h7E);
    check("R10 idle ext float", p0Float, 1);
    irqEn = 5'b00100;
    step();
    check("R3 enabled irq wakes", cpuClkEn, 1);
    check("R2 flags kept idle cleared", pconRead, 4'b0100);
    irqReq = '0; irqEn = '0;
    step(2);

    // R1 priority, R5 irqs ignored, R11 ext pins
    writeReg(4'b1011);
    check("R1 both bits gives power-down", oscEn, 0);
    check("R1 only power-down bit stored", pconRead, 4'b1010);
    irqReq = '1; irqEn = '1;
    step(10);
    check("R5 irq ignored in power-down", cpuClkEn, 0);
    check("R11 pd ext p2 latch", p2, 8'hC2);
    check("R8 pd strobes low", {ale, psen}, 2'b00);
    hwRst = 1'b1;
    step();
    check("R5 reset restarts oscillator", oscEn, 1);
    check("R5 register cleared", pconRead, 4'h0);
    step(3);
    hwRst = 1'b0;
    step(5);
    hwRst = 1'b1;   // R6 count restarts
    step();
    hwRst = 1'b0;
    irqReq = '0; irqEn = '0;
    for (int i = 1; i <= STABLE_CYCLES; i++) begin
      step();
      check("R6 release after stable count", cpuClkEn, i == STABLE_CYCLES);
    end
    step(2);

    // R9 internal memory power-down pins
    extCode = 1'b0;
    writeReg(4'b0010);
    check("R9 int pd p0", p0, 8'hA0);
    check("R9 int pd p2", p2, 8'hC2);
    hwRst = 1'b1;
    step(2);
    hwRst = 1'b0;
    step(STABLE_CYCLES + 2);

    // R7 short pulse in idle, then full reset
    writeReg(4'b1001);
    hwRst = 1'b1;
    step(RST_CYCLES - 2);
    hwRst = 1'b0;
    step();
    check("R7 short pulse keeps idle", cpuClkEn, 0);
    check("R7 short pulse keeps register", pconRead, 4'b1001);
    hwRst = 1'b1;
    for (int i = 1; i <= RST_CYCLES; i++) begin
      step();
      check("R7 reset ends idle at count", cpuClkEn, i == RST_CYCLES);
    end
    check("R7 core reset asserted", coreRstOut, 1);
    check("R7 register cleared", pconRead, 4'h0);
    step(3);
    hwRst = 1'b0;
    step();
    check("R7 core reset released", coreRstOut, 0);

    // R7 long reset while running clears flags
    writeReg(4'b1100);
    hwRst = 1'b1;
    step(RST_CYCLES + 2);
    hwRst = 1'b0;
    step(2);
    check("R7 running reset clears flags", pconRead, 4'h0);
    summary();
  end
endmodule